// File: doc/BRIEF.md
# Per-Block Write Protection Manager

This block holds a protection attribute for every erase block of a flash array and changes those attributes in response to range commands. Each block is in exactly one of three states: unlocked, locked, or lock-tight. Software programs a first and a last block index, then issues one of four commands: unlock a range, lock a range, lock-tight a range, or unlock the whole array. The manager visits one block per clock and applies the transition rules as it goes. The rules are not symmetric. A lock-tight block cannot be changed by lock or unlock. An unlocked block cannot be changed by lock-tight.

While a command runs, `busy` is high. At the end, `done` pulses for one cycle. If the walk reaches an index past the last real block, it stops and raises `cmd_err`. The most recent state that was actually written is kept in `wp_status`. A combinational query port returns the state of any one block. Program and erase logic elsewhere uses that port to gate its operations.

Top module: `blk_protect_mgr`

## Requirements
- R1: States are one-hot on 3 bits: bit 0 (3'b001) is lock-tight, bit 1 (3'b010) is locked, bit 2 (3'b100) is unlocked. `q_state` returns the state of block `q_blk` in the same cycle. It returns 3'b000 when `q_blk` is not below `N_BLOCKS`.
- R2: After reset, every block is locked, `wp_status` is 3'b010, `busy`, `done` and `cmd_err` are 0, and both range registers are 0.
- R3: Command 8'h23 sets every block from start to end inclusive to unlocked. Lock-tight blocks are left unchanged.
- R4: Command 8'h2A sets every block in the range to locked. Lock-tight blocks are left unchanged.
- R5: Command 8'h2C sets every block in the range to lock-tight. Unlocked blocks are left unchanged.
- R6: Command 8'h27 walks blocks 0 to `N_BLOCKS`-1 and unlocks every block that is not lock-tight. It ignores the range registers.
- R7: If the walk reaches an index of `N_BLOCKS` or more, that block and all later ones are left untouched, and the walk ends. `cmd_err` is set and stays set until the next command is accepted, which clears it. Blocks in the range below `N_BLOCKS` are still applied.
- R8: Each state written into a block is also written into `wp_status`. A skipped block leaves `wp_status` unchanged.
- R9: A write to the start register stores the low `IDX_W` bits of `wr_data` into both the start and end registers. A write to the end register changes only the end register, and it takes precedence when both writes happen in the same cycle.
- R10: A command is accepted when `cmd_valid` is high, the block is idle, and the code is one of the four above.
  - `busy` is then high for exactly V cycles, where V is the number of block indices visited. V is 1 when start is greater than end; in that case nothing changes.
  - `done` is high for the single cycle after that.
  - Unknown codes and commands issued while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write start-block register (also copies to end) |
| wr_end | input | 1 | Write end-block register |
| wr_data | input | DATA_W | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| q_blk | input | IDX_W | Block index to query |
| q_state | output | 3 | One-hot state of the queried block |
| start_blk | output | IDX_W | Start-block register |
| end_blk | output | IDX_W | End-block register |
| wp_status | output | 3 | Last state written to any block |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at walk end |
| cmd_err | output | 1 | Walk ran past the array |

## Verification
The bench builds the block with `N_BLOCKS` = 12, so the index field is 4 bits wide. A range can therefore name indices 12 to 15, which lie past the array, and this makes the overrun error in R7 reachable. Using a block count that is not a power of two also checks that unlock-all stops at block 11 and does not wrap at the field width. A bench-side model of the transition rules predicts every block's state, `wp_status`, the error flag and the number of busy cycles for each command in a sequence. The sequence is chosen so that every skip rule fires.

// File: rtl/blk_protect_mgr.sv
module blk_protect_mgr #(
  parameter int N_BLOCKS = 16,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(N_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [IDX_W-1:0]  q_blk,
  output logic [2:0]        q_state,
  output logic [IDX_W-1:0]  start_blk,
  output logic [IDX_W-1:0]  end_blk,
  output logic [2:0]        wp_status,
  output logic              busy,
  output logic              done,
  output logic              cmd_err
);
  localparam logic [2:0] S_TIGHT = 3'b001;
  localparam logic [2:0] S_LOCK  = 3'b010;
  localparam logic [2:0] S_UNL   = 3'b100;
  localparam logic [7:0] C_UNL   = 8'h23;
  localparam logic [7:0] C_ALL   = 8'h27;
  localparam logic [7:0] C_LOCK  = 8'h2A;
  localparam logic [7:0] C_TIGHT = 8'h2C;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BLOCKS - 1);

  logic [2:0]       st [N_BLOCKS];
  logic [IDX_W-1:0] cur, lim;
  logic [7:0]       op;
  logic [2:0]       cur_st, nxt;
  logic             known, in_arr, apply;

  assign known  = (cmd_code == C_UNL) || (cmd_code == C_ALL) ||
                  (cmd_code == C_LOCK) || (cmd_code == C_TIGHT);
  assign in_arr = 32'(cur) < N_BLOCKS;
  assign cur_st = in_arr ? st[cur] : 3'b000;
  assign nxt    = (op == C_TIGHT) ? S_TIGHT : (op == C_LOCK) ? S_LOCK : S_UNL;
  assign apply  = (op == C_TIGHT) ? (cur_st != S_UNL) : (cur_st != S_TIGHT);
  assign q_state = (32'(q_blk) < N_BLOCKS) ? st[q_blk] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_BLOCKS; i++) st[i] <= S_LOCK;
      start_blk <= '0;
      end_blk   <= '0;
      wp_status <= S_LOCK;
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      cur       <= '0;
      lim       <= '0;
      op        <= 8'h00;
    end else begin
      done <= 1'b0;
      if (wr_start) start_blk <= wr_data[IDX_W-1:0];
      if (wr_end)        end_blk <= wr_data[IDX_W-1:0];
      else if (wr_start) end_blk <= wr_data[IDX_W-1:0];

      if (!busy && cmd_valid && known) begin
        busy    <= 1'b1;
        cmd_err <= 1'b0;
        op      <= cmd_code;
        cur     <= (cmd_code == C_ALL) ? '0 : start_blk;
        lim     <= (cmd_code == C_ALL) ? LAST : end_blk;
      end else if (busy) begin
        if (cur > lim) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (!in_arr) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          cmd_err <= 1'b1;
        end else begin
          if (apply) begin
            st[cur]   <= nxt;
            wp_status <= nxt;
          end
          if (cur == lim) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cur <= cur + 1'b1;
          end
        end
      end
    end
  end
endmodule

module blk_protect_mgr_chk #(
  parameter int N_BLOCKS = 16,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(N_BLOCKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_start,
  input logic              wr_end,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  q_blk,
  input logic [2:0]        q_state,
  input logic [IDX_W-1:0]  start_blk,
  input logic [IDX_W-1:0]  end_blk,
  input logic [2:0]        wp_status,
  input logic              busy,
  input logic              done
);
  a_r1_query_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(q_blk) < N_BLOCKS) |-> ($countones(q_state) == 1));
  a_r8_wp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wp_status) == 1);
  a_r9_start_copies_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !wr_end) |=> (end_blk == start_blk));
  a_r9_end_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !wr_start) |=> $stable(start_blk));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind blk_protect_mgr blk_protect_mgr_chk #(.N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end), .wr_data(wr_data),
  .q_blk(q_blk), .q_state(q_state), .start_blk(start_blk), .end_blk(end_blk),
  .wp_status(wp_status), .busy(busy), .done(done));

// File: tb/blk_protect_mgr_bench.sv
module blk_protect_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;
  localparam int IW = $clog2(NB);
  localparam logic [2:0] T = 3'b001, L = 3'b010, U = 3'b100;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, wr_end = 0, cmd_valid = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] cmd_code = 0;
  logic [IW-1:0] q_blk = 0;
  logic [2:0] q_state, wp_status;
  logic [IW-1:0] start_blk, end_blk;
  logic busy, done, cmd_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_protect_mgr #(.N_BLOCKS(NB), .DATA_W(16)) u_blk_protect_mgr (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .q_blk(q_blk), .q_state(q_state),
    .start_blk(start_blk), .end_blk(end_blk), .wp_status(wp_status),
    .busy(busy), .done(done), .cmd_err(cmd_err));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] m [NB];
  logic [2:0] m_wp;
  logic m_err;
  int m_vis;

  // {start, end, code}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2, 4'd5, 8'h23},   // R3
    {4'd4, 4'd8, 8'h2C},   // R5
    {4'd0, 4'd11, 8'h2A},  // R4
    {4'd3, 4'd1, 8'h27},   // R6
    {4'd0, 4'd3, 8'h2C},   // R5 all skipped
    {4'd7, 4'd7, 8'h2A},   // R4 tight skipped
    {4'd10, 4'd14, 8'h23}, // R7
    {4'd9, 4'd3, 8'h2A},   // R10 empty
    {4'd1, 4'd2, 8'h2A},   // R4
    {4'd0, 4'd2, 8'h2C}    // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input bit is_start, input logic [15:0] v);
    @(negedge clk);
    wr_start = is_start; wr_end = !is_start; wr_data = v;
    @(negedge clk);
    wr_start = 0; wr_end = 0;
  endtask

  task automatic model(input int s, input int e, input logic [7:0] c);
    int lo, hi;
    logic [2:0] nx;
    lo = (c == 8'h27) ? 0 : s;
    hi = (c == 8'h27) ? NB-1 : e;
    nx = (c == 8'h2C) ? T : (c == 8'h2A) ? L : U;
    m_err = 0; m_vis = 0;
    if (lo > hi) m_vis = 1;
    else for (int b = lo; b <= hi; b++) begin
      m_vis++;
      if (b >= NB) begin m_err = 1; break; end
      if ((c == 8'h2C) ? (m[b] != U) : (m[b] != T)) begin m[b] = nx; m_wp = nx; end
    end
  endtask

  task automatic run_cmd(input logic [7:0] c, output int nbusy);
    int guard;
    @(negedge clk);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0;
    nbusy = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) nbusy++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      q_blk = IW'(b);
      #1;
      chk(tag, {29'd0, q_state}, {29'd0, m[b]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb;
    for (int b = 0; b < NB; b++) m[b] = L;
    m_wp = L;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    cmp_all("R2 reset state");
    chk("R2 wp_status", {29'd0, wp_status}, {29'd0, L});
    chk("R2 busy/done/err", {29'd0, busy, done, cmd_err}, 32'd0);
    chk("R2 range regs", {24'd0, start_blk, end_blk}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      int s, e;
      s = int'(VEC[v][15:12]); e = int'(VEC[v][11:8]);
      wreg(1, 16'(s));
      if (e != s) wreg(0, 16'(e));
      model(s, e, VEC[v][7:0]);
      run_cmd(VEC[v][7:0], nb);
      chk($sformatf("R10 busy cycles vec%0d", v), nb, m_vis);
      chk($sformatf("R10 done pulse vec%0d", v), {31'd0, done}, 32'd1);
      @(negedge clk);
      chk($sformatf("R10 done low vec%0d", v), {31'd0, done}, 32'd0);
      chk($sformatf("R7 cmd_err vec%0d", v), {31'd0, cmd_err}, {31'd0, m_err});
      chk($sformatf("R8 wp_status vec%0d", v), {29'd0, wp_status}, {29'd0, m_wp});
      cmp_all($sformatf("R3/R4/R5/R6 states vec%0d", v));
    end

    // R1 out-of-range query
    q_blk = 4'd13; #1;
    chk("R1 query beyond array", {29'd0, q_state}, 32'd0);

    // R9 start write masked and copied, end write only end
    wreg(1, 16'hFFF5);
    chk("R9 start masked", {28'd0, start_blk}, 32'd5);
    chk("R9 end copied", {28'd0, end_blk}, 32'd5);
    wreg(0, 16'h0008);
    chk("R9 end only start", {28'd0, start_blk}, 32'd5);
    chk("R9 end only end", {28'd0, end_blk}, 32'd8);

    // R10 unknown code ignored
    @(negedge clk); cmd_valid = 1; cmd_code = 8'h55;
    @(negedge clk); cmd_valid = 0;
    chk("R10 unknown code busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R10 unknown code done", {31'd0, done}, 32'd0);
    cmp_all("R10 unknown code states");

    // R10 command while busy ignored: lock 5..8, then unlock-all mid-walk
    model(5, 8, 8'h2A);
    @(negedge clk); cmd_valid = 1; cmd_code = 8'h2A;
    @(negedge clk); cmd_code = 8'h27;
    @(negedge clk); cmd_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    cmp_all("R10 busy command ignored");
    chk("R8 wp after busy test", {29'd0, wp_status}, {29'd0, m_wp});

    // R7 error cleared by next accepted command
    wreg(1, 16'd14);
    model(14, 14, 8'h23);
    run_cmd(8'h23, nb);
    @(negedge clk);
    chk("R7 error set", {31'd0, cmd_err}, 32'd1);
    wreg(1, 16'd0);
    model(0, 0, 8'h23);
    run_cmd(8'h23, nb);
    @(negedge clk);
    chk("R7 error cleared", {31'd0, cmd_err}, 32'd0);
    cmp_all("R3 final states");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule